// File: doc/BRIEF.md
# Dual Event Performance Counter

This block is a per-core performance monitor holding two 32-bit event counters, named upper and lower. Each counter follows one of several per-cycle event strobes from the core (clock cycle, retired instruction, cache access, cache miss, retired marker NOP), picked by its own 6-bit event code in a shared control register. Counting is gated by three privilege-context enables that both counters share, so a single counter cannot be stopped through the enables. Software idles one counter by selecting the marker-NOP event, which almost never fires.

Both counters are reached through one 64-bit counter register. A write loads both counters in the same cycle. When a counter rolls over from all ones to zero, its sticky overflow flag is set. The OR of the two flags drives a level interrupt. Software clears a flag by writing 1 to its bit in a status register. The register port is a simple write strobe with a 2-bit select and a combinational read.

Top module: `dual_evt_counter`

## Requirements
- R1: After reset, both counters, the control register and both overflow flags read zero, and `irq` is low.
- R2: Select 0 is the control register. Bit 0 is a privileged-access bit. Bit 1 is the supervisor enable, bit 2 the user enable and bit 3 the hypervisor enable. Bits 9:4 hold the lower counter's event code and bits 16:11 hold the upper counter's event code. Every other bit reads zero. Select 3 reads zero, and writes to it change nothing.
- R3: Select 1 is the counter register, with the upper counter in bits 63:32 and the lower counter in bits 31:0. A write loads both counters, and a read returns both.
- R4: Event code 0x00 counts clock-cycle strobes and code 0x01 counts retired-instruction strobes, on either counter.
- R5: Code 0x09 counts cache accesses on the lower counter and cache misses on the upper counter. Code 0x14 on the lower counter and code 0x1C on the upper counter count marker-NOP strobes. Any other code, including the other counter's marker code, counts nothing.
- R6: `priv_mode` is encoded as 0 user, 1 supervisor, 2 hypervisor and 3 none. A counter advances only when the enable bit for the current mode is set. Mode 3 never counts, and clearing all three enables stops both counters.
- R7: A counter advances by at most one per cycle, even when several strobes are high.
- R8: A write to the counter register in a cycle where a counter would advance loads the written value, and that increment is dropped.
- R9: A wrap of a counter from 0xFFFFFFFF to 0 sets that counter's own sticky flag. Select 2 reads the upper flag in bit 0 and the lower flag in bit 1. `irq` is high while either flag is set.
- R10: Writing select 2 with a 1 in a flag's bit clears that flag, and a 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cycle | input | 1 | Clock-cycle event strobe |
| ev_retire | input | 1 | Instruction-retired strobe |
| ev_cache_acc | input | 1 | Cache-access strobe |
| ev_cache_miss | input | 1 | Cache-miss strobe |
| ev_marker | input | 1 | Marker-NOP retired strobe |
| priv_mode | input | 2 | Current privilege mode |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 counters, 2 status) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_sel` |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions take for granted that `reg_wr`, `reg_sel`, `priv_mode` and the strobes are settled, known values at each rising edge. They also assume that any strobe pattern and mode value may arrive in any cycle. The checks on step size and load priority rely on a load being the only way a counter can jump by more than one. The stimulus changes inputs only at the falling edge and uses only the four select and mode codes. It builds control writes mostly from the meaningful event codes and seeds counter writes just below the wrap point, so wraps, simultaneous set-and-clear of a flag and load-versus-increment collisions all occur often.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef struct packed {
    logic marker;
    logic cmiss;
    logic cacc;
    logic ret;
    logic cyc;
  } evt_strobe_t;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_HYPV = 2'd2,
    MODE_NONE = 2'd3
  } pmode_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int CODE_CYC     = 'h00;
  localparam int CODE_RET     = 'h01;
  localparam int CODE_CACHE   = 'h09;
  localparam int CODE_MARK_UP = 'h1C;
  localparam int CODE_MARK_LO = 'h14;

  // en = {hypervisor, user, supervisor}
  function automatic logic ctx_allows(input logic [2:0] en, input logic [1:0] mode);
    case (mode)
      MODE_USER: ctx_allows = en[1];
      MODE_SUPV: ctx_allows = en[0];
      MODE_HYPV: ctx_allows = en[2];
      default:   ctx_allows = 1'b0;
    endcase
  endfunction

  function automatic logic all_ones(input logic [31:0] v);
    all_ones = &v;
  endfunction

endpackage

// File: rtl/dpc_evt_sel.sv
module dpc_evt_sel
  import dpc_pkg::*;
#(
  parameter int EVT_W    = 6,
  parameter bit IS_UPPER = 1'b0
) (
  input  logic [EVT_W-1:0] code,
  input  evt_strobe_t      strb,
  output logic             hit
);

  logic             shared_src;
  logic [EVT_W-1:0] mark_code;

  generate
    if (IS_UPPER) begin : g_up
      assign shared_src = strb.cmiss;
      assign mark_code  = EVT_W'(CODE_MARK_UP);
    end else begin : g_lo
      assign shared_src = strb.cacc;
      assign mark_code  = EVT_W'(CODE_MARK_LO);
    end
  endgenerate

  always_comb begin
    if (code == EVT_W'(CODE_CYC))        hit = strb.cyc;
    else if (code == EVT_W'(CODE_RET))   hit = strb.ret;
    else if (code == EVT_W'(CODE_CACHE)) hit = shared_src;
    else if (code == mark_code)          hit = strb.marker;
    else                                 hit = 1'b0;
  end

endmodule

// File: rtl/dpc_lane.sv
module dpc_lane #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             wrap
);

  assign wrap = inc && !ld && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (ld)       count <= ld_val;
      else if (inc) count <= count + 1'b1;
      flag <= wrap | (flag & ~clr);
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(ld_val)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))); // R7
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && (&count)) |=> flag); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R10

endmodule

// File: rtl/dual_evt_counter.sv
module dual_evt_counter
  import dpc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int EVT_W  = 6,
  parameter int LO_LSB = 4,
  parameter int UP_LSB = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cycle,
  input  logic              ev_retire,
  input  logic              ev_cache_acc,
  input  logic              ev_cache_miss,
  input  logic              ev_marker,
  input  logic [1:0]        priv_mode,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq
);

  localparam int REG_W = 2 * CNT_W;
  localparam logic [REG_W-1:0] FIELD_ONES = REG_W'((1 << EVT_W) - 1);
  localparam logic [REG_W-1:0] CTRL_MASK  = REG_W'(15) | (FIELD_ONES << LO_LSB) | (FIELD_ONES << UP_LSB);

  evt_strobe_t      strb;
  logic [REG_W-1:0] ctrl_q;
  logic [2:0]       ctx_en;
  logic             ctx_ok;
  logic             cnt_wr;
  logic             st_wr;
  logic [1:0]       hit;
  logic [1:0]       flg;
  logic [1:0]       wrap;
  logic [CNT_W-1:0] cnt [2];
  logic [REG_W-1:0] cnt_bus;

  assign strb   = '{marker: ev_marker, cmiss: ev_cache_miss, cacc: ev_cache_acc,
                    ret: ev_retire, cyc: ev_cycle};
  assign ctx_en = {ctrl_q[3], ctrl_q[2], ctrl_q[1]};
  assign ctx_ok = ctx_allows(ctx_en, priv_mode);
  assign cnt_wr = reg_wr && (reg_sel == SEL_CNT);
  assign st_wr  = reg_wr && (reg_sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)                               ctrl_q <= '0;
    else if (reg_wr && reg_sel == SEL_CTRL)   ctrl_q <= reg_wdata & CTRL_MASK;
  end

  // lane 0 = upper counter, lane 1 = lower counter
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam bit IS_UP  = (g == 0);
    localparam int F_LSB  = IS_UP ? UP_LSB : LO_LSB;
    localparam int D_LSB  = IS_UP ? CNT_W : 0;

    dpc_evt_sel #(.EVT_W(EVT_W), .IS_UPPER(IS_UP)) i_sel (
      .code (ctrl_q[F_LSB +: EVT_W]),
      .strb (strb),
      .hit  (hit[g])
    );

    dpc_lane #(.CNT_W(CNT_W)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cnt_wr),
      .ld_val (reg_wdata[D_LSB +: CNT_W]),
      .inc    (hit[g] && ctx_ok),
      .clr    (st_wr && reg_wdata[g]),
      .count  (cnt[g]),
      .flag   (flg[g]),
      .wrap   (wrap[g])
    );
  end

  assign cnt_bus = {cnt[0], cnt[1]};

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_CNT:  reg_rdata = cnt_bus;
      SEL_STAT: reg_rdata = {{(REG_W-2){1'b0}}, flg};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |flg;

  AST_IDLE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_ok && !cnt_wr) |=> $stable(cnt_bus)); // R6
  AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|wrap)); // R9

endmodule

// File: tb/test_dual_evt_counter.sv
module test_dual_evt_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_cycle = 0, ev_retire = 0, ev_cache_acc = 0, ev_cache_miss = 0, ev_marker = 0;
  logic [1:0]  priv_mode = 2'd0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  bit [63:0] m_ctrl;
  bit [31:0] m_up, m_lo;
  bit [1:0]  m_flg;

  always #10 clk = ~clk;

  dual_evt_counter i_dual_evt_counter (
    .clk(clk), .rst_n(rst_n), .ev_cycle(ev_cycle), .ev_retire(ev_retire),
    .ev_cache_acc(ev_cache_acc), .ev_cache_miss(ev_cache_miss), .ev_marker(ev_marker),
    .priv_mode(priv_mode), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // st = {marker, miss, access, retire, cycle}
  function automatic bit b_hit(bit up, bit [5:0] code, bit [4:0] st);
    bit r = 0;
    if (code == 6'h00) r = st[0];
    if (code == 6'h01) r = st[1];
    if (code == 6'h09) r = up ? st[3] : st[2];
    if (up && code == 6'h1C) r = st[4];
    if (!up && code == 6'h14) r = st[4];
    return r;
  endfunction

  function automatic bit b_ctx(bit [63:0] c, bit [1:0] md);
    return (md == 0 && c[2]) || (md == 1 && c[1]) || (md == 2 && c[3]);
  endfunction

  function automatic bit [63:0] b_read(bit [1:0] sel);
    if (sel == 0) return m_ctrl;
    if (sel == 1) return {m_up, m_lo};
    if (sel == 2) return {62'd0, m_flg};
    return 64'd0;
  endfunction

  task automatic step(bit wr, bit [1:0] sel, bit [63:0] wd, bit [4:0] st, bit [1:0] md);
    bit ok, iu, il, ld, su, sl;
    bit [1:0] clr;
    {ev_marker, ev_cache_miss, ev_cache_acc, ev_retire, ev_cycle} = st;
    priv_mode = md; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ok = b_ctx(m_ctrl, md);
    iu = ok && b_hit(1, m_ctrl[16:11], st);
    il = ok && b_hit(0, m_ctrl[9:4], st);
    ld = wr && sel == 1;
    su = iu && !ld && m_up == 32'hFFFF_FFFF;
    sl = il && !ld && m_lo == 32'hFFFF_FFFF;
    clr = (wr && sel == 2) ? wd[1:0] : 2'b00;
    m_flg = {sl, su} | (m_flg & ~clr);
    if (ld) begin m_up = wd[63:32]; m_lo = wd[31:0]; end
    else begin m_up = m_up + 32'(iu); m_lo = m_lo + 32'(il); end
    if (wr && sel == 0) m_ctrl = wd & 64'h1_FBFF;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic peek(bit [1:0] sel, string req);
    {ev_marker, ev_cache_miss, ev_cache_acc, ev_retire, ev_cycle} = '0;
    reg_wr = 0; reg_sel = sel;
    #1;
    n_chk++;
    if (reg_rdata !== b_read(sel) || irq !== (|m_flg)) begin
      n_err++;
      $display("FAIL %s sel=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
               req, sel, reg_rdata, irq, b_read(sel), |m_flg);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ctrl = 0; m_up = 0; m_lo = 0; m_flg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(0, "R1"); peek(1, "R1"); peek(2, "R1");
    // R2 control layout, unused select
    step(1, 0, '1, 0, 0); peek(0, "R2");
    step(1, 3, '1, 0, 0); peek(3, "R2"); peek(0, "R2"); peek(1, "R2");
    // R3 counter register
    step(1, 1, 64'h1234_5678_9ABC_DEF0, 0, 0); peek(1, "R3");
    // R4 cycles upper, retire lower, user enabled
    step(1, 0, 64'h0 | (64'h00 << 11) | (64'h01 << 4) | 64'h4, 0, 0);
    step(0, 0, 0, 5'b00001, 0); peek(1, "R4");
    step(0, 0, 0, 5'b00010, 0); peek(1, "R4");
    // R5 shared code and markers
    step(1, 0, (64'h09 << 11) | (64'h09 << 4) | 64'h4, 0, 0);
    step(0, 0, 0, 5'b00100, 0); peek(1, "R5");
    step(0, 0, 0, 5'b01000, 0); peek(1, "R5");
    step(1, 0, (64'h1C << 11) | (64'h14 << 4) | 64'h4, 0, 0);
    step(0, 0, 0, 5'b10000, 0); peek(1, "R5");
    step(1, 0, (64'h14 << 11) | (64'h1C << 4) | 64'h4, 0, 0);
    step(0, 0, 0, 5'b11111, 0); peek(1, "R5");
    step(1, 0, (64'h3F << 11) | (64'h05 << 4) | 64'h4, 0, 0);
    step(0, 0, 0, 5'b11111, 0); peek(1, "R5");
    // R6 context gating
    step(1, 0, 64'h2, 0, 0);
    step(0, 0, 0, 5'b11111, 0); peek(1, "R6");
    step(0, 0, 0, 5'b11111, 1); peek(1, "R6");
    step(1, 0, 64'hE, 0, 0);
    step(0, 0, 0, 5'b11111, 3); peek(1, "R6");
    step(0, 0, 0, 5'b11111, 2); peek(1, "R6");
    // R7 many strobes, one step
    step(0, 0, 0, 5'b11111, 0); peek(1, "R7");
    // R8 write beats increment
    step(1, 1, 64'h0000_0010_0000_0020, 5'b11111, 0); peek(1, "R8");
    // R9 wrap of upper only
    step(1, 1, 64'hFFFF_FFFF_0000_0000, 0, 0);
    step(0, 0, 0, 5'b00001, 0); peek(1, "R9"); peek(2, "R9");
    // R10 clear with 0 keeps, clear with 1 clears, set beats clear
    step(1, 2, 64'h2, 0, 0); peek(2, "R10");
    step(1, 2, 64'h1, 0, 0); peek(2, "R10");
    step(1, 1, 64'h0000_0000_FFFF_FFFF, 0, 0);
    step(1, 2, 64'h3, 5'b00001, 0); peek(2, "R10"); peek(1, "R10");
    // R7 random mixture against the bench model
    for (int i = 0; i < 3000; i++) begin
      bit wr;
      bit [1:0] sel;
      bit [63:0] wd;
      bit [5:0] codes [5] = '{6'h00, 6'h01, 6'h09, 6'h14, 6'h1C};
      wr  = ($urandom % 8) == 0;
      sel = 2'($urandom % 4);
      wd  = {$urandom, $urandom};
      if (sel == 0) begin
        wd[16:11] = codes[$urandom % 5];
        wd[9:4]   = ($urandom % 6 == 0) ? 6'($urandom) : codes[$urandom % 5];
      end
      if (sel == 1) begin
        wd[63:32] = 32'hFFFF_FFF0 | 32'($urandom % 16);
        wd[31:0]  = 32'hFFFF_FFF0 | 32'($urandom % 16);
      end
      step(wr, sel, wd, 5'($urandom), 2'($urandom));
      peek(2'($urandom), "R7");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule